// File: doc/BRIEF.md
# Low-speed USB NRZI Packet Transmitter

This block puts one low-speed USB packet onto the differential data pair. On a start strobe it latches a byte count, takes ownership of the pair in the idle (J) state, and serialises the packet. The packet is the SYNC pattern, which the block generates itself, followed by the data bytes, which it reads from a byte source outside the block. Every byte is sent least significant bit first, NRZI-coded, with a stuffed transition inserted after any six consecutive ones. It then signals end-of-packet, returns the pair to J for one bit time and releases the drivers. The caller supplies the bytes already complete, CRC included.

The byte count includes the SYNC byte, so a count of N causes N-1 reads from the source. The indices of these reads run from 0 upward. Reads are issued one byte ahead of the serialiser, so the bit stream has no gaps. The clock runs at a fixed multiple of the bit rate (8 by default). A busy flag covers the whole time the block owns the pair, and a one-cycle done pulse marks its release.

Top module: `usb_ls_nrzi_tx`

## Requirements
- R1: After reset, oe_o, busy_o, done_o and fetch_req_o are all low.
- R2: A start_i pulse is accepted only while idle and only with byte_cnt_i in 1..255. A start with count 0, or a start while busy, has no effect on the pair or on the packet being sent.
- R3: In the cycle after acceptance the pair shows J ({dp_o,dm_o} = 2'b01) with oe_o low. In the next cycle it shows J with oe_o high, and the first bit begins one cycle later.
- R4: The first byte serialised is SYNC 0x80, generated internally. It is followed by byte_cnt_i-1 fetched bytes, each sent bit 0 first.
- R5: NRZI coding: a 0 bit toggles the pair between J (2'b01) and K (2'b10), and a 1 bit leaves it unchanged. The line starts from J.
- R6: After six consecutive 1 bits (the run counted across byte boundaries), one extra toggle is sent and the run count restarts. This also applies after the last data bit, before end-of-packet. A stuffed bit consumes no data bit.
- R7: Every bit, stuffed or not, lasts CLKS_PER_BIT clocks (8 by default).
- R8: After the last bit the pair shows SE0 (2'b00) for two bit times (16 clocks) and then J for one bit time. Then oe_o falls.
- R9: busy_o is high from the cycle after acceptance until the cycle oe_o falls. done_o is a single-cycle pulse in that same cycle.
- R10: fetch_req_o is a one-cycle pulse with the index on fetch_idx_o. The source must present that byte on fetch_data_i during the following cycle. Indices run 0..byte_cnt_i-2, each requested once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLKS_PER_BIT times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| byte_cnt_i | input | 8 | Packet length in bytes including SYNC (1..255) |
| fetch_req_o | output | 1 | One-cycle byte read request |
| fetch_idx_o | output | 8 | Index of the requested data byte |
| fetch_data_i | input | 8 | Requested byte, valid the cycle after the request |
| dp_o | output | 1 | D+ value |
| dm_o | output | 1 | D- value |
| oe_o | output | 1 | Driver enable for both lines |
| busy_o | output | 1 | Block owns or is preparing the pair |
| done_o | output | 1 | One-cycle pulse at release |

## Verification
Directed packets compare the pair value in the first clock of every bit slot against a symbol stream that the bench derives from the requirements. A SYNC-only packet isolates the preamble and end-of-packet framing. Alternating and all-zero bytes exercise plain NRZI toggling with no stuffing. All-ones bytes force stuffing in mid-byte and across byte boundaries, and the byte 0xFC forces a stuffed bit right before SE0, which separates a correct end check from one that drops the trailing stuff. A 255-byte packet and the ignored-start cases (count 0, and a start during a packet) check the count limits and that the prefetch keeps pace.

// File: rtl/usb_ls_tx_pkg.sv
// Shared types for the low-speed USB packet transmitter.
// Assumes pair symbols are written as {dp, dm}.
package usb_ls_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_BITS,
        ST_EOP,
        ST_JEND
    } tx_state_e;

    localparam logic [1:0] SYM_J   = 2'b01;
    localparam logic [1:0] SYM_K   = 2'b10;
    localparam logic [1:0] SYM_SE0 = 2'b00;

endpackage

// File: rtl/usb_tx_bit_timer.sv
// Bit-slot timer: while run_i is high it divides the clock by CLKS_PER_BIT
// and pulses strobe_o in the first clock of every bit slot.
// Assumes run_i rises exactly at the start of the first slot.
module usb_tx_bit_timer #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic strobe_o
);
    localparam int TW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [TW-1:0] LAST = TW'(CLKS_PER_BIT - 1);

    logic [TW-1:0] tick_q;

    // Count clocks inside the current bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            tick_q <= '0;
        end else if (tick_q == LAST) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign strobe_o = run_i && (tick_q == '0);

endmodule

// File: rtl/usb_tx_byte_feeder.sv
// One-byte-ahead fetch stage. After load_i it requests data bytes 0..count-1
// from an outside source, one at a time, and holds the next byte for the
// serialiser until take_i pops it.
// Assumes the source answers a request in the cycle after fetch_req_o.
module usb_tx_byte_feeder #(
    parameter int CNT_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              active_i,
    input  logic              take_i,
    output logic              fetch_req_o,
    output logic [CNT_W-1:0]  fetch_idx_o,
    input  logic [BYTE_W-1:0] fetch_data_i,
    output logic              nxt_valid_o,
    output logic [BYTE_W-1:0] nxt_byte_o
);
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  idx_q;
    logic              req_q;
    logic              cap_q;
    logic              valid_q;
    logic [BYTE_W-1:0] hold_q;

    // Issue requests, capture answers and track the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            idx_q    <= '0;
            req_q    <= 1'b0;
            cap_q    <= 1'b0;
            valid_q  <= 1'b0;
            hold_q   <= '0;
        end else if (load_i) begin
            remain_q <= count_i;
            idx_q    <= '0;
            req_q    <= 1'b0;
            cap_q    <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            req_q <= active_i && !valid_q && !req_q && !cap_q && (remain_q != '0);
            cap_q <= req_q;
            if (take_i) begin
                valid_q <= 1'b0;
            end
            if (cap_q) begin
                hold_q   <= fetch_data_i;
                valid_q  <= 1'b1;
                idx_q    <= idx_q + 1'b1;
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign fetch_req_o = req_q;
    assign fetch_idx_o = idx_q;
    assign nxt_valid_o = valid_q;
    assign nxt_byte_o  = hold_q;

endmodule

// File: rtl/usb_tx_nrzi_stuffer.sv
// Serialiser with NRZI coding and bit stuffing. On each strobe_i it either
// inserts a stuffed toggle (after STUFF_RUN ones), sends the next data bit
// (LSB first), or, with no data left, reports the end of the bit stream.
// Assumes init_i comes at least one cycle before the first strobe_i.
module usb_tx_nrzi_stuffer #(
    parameter int BYTE_W    = 8,
    parameter int STUFF_RUN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              strobe_i,
    input  logic              nxt_valid_i,
    input  logic [BYTE_W-1:0] nxt_byte_i,
    output logic              take_o,
    output logic              end_o,
    output logic              line_k_o
);
    localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam int OW = $clog2(STUFF_RUN + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);
    localparam logic [OW-1:0] RUN_MAX  = OW'(STUFF_RUN);
    localparam logic [BYTE_W-1:0] SYNC_PAT = BYTE_W'(1) << (BYTE_W - 1);

    logic [BYTE_W-1:0] sh_q;
    logic [BW-1:0]     bit_q;
    logic [OW-1:0]     ones_q;
    logic              have_q;
    logic              line_q;
    logic              stuff_now;
    logic              send_now;

    assign stuff_now = strobe_i && (ones_q == RUN_MAX);
    assign send_now  = strobe_i && (ones_q != RUN_MAX) && have_q;
    assign end_o     = strobe_i && (ones_q != RUN_MAX) && !have_q;
    assign take_o    = send_now && (bit_q == LAST_BIT) && nxt_valid_i;
    assign line_k_o  = line_q;

    // Advance line state, ones run and data position once per bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bit_q  <= '0;
            ones_q <= '0;
            have_q <= 1'b0;
            line_q <= 1'b0;
        end else if (init_i) begin
            sh_q   <= SYNC_PAT;
            bit_q  <= '0;
            ones_q <= '0;
            have_q <= 1'b1;
            line_q <= 1'b0;
        end else if (stuff_now) begin
            line_q <= ~line_q;
            ones_q <= '0;
        end else if (send_now) begin
            if (sh_q[0]) begin
                ones_q <= ones_q + 1'b1;
            end else begin
                line_q <= ~line_q;
                ones_q <= '0;
            end
            if (bit_q == LAST_BIT) begin
                bit_q <= '0;
                if (nxt_valid_i) begin
                    sh_q <= nxt_byte_i;
                end else begin
                    have_q <= 1'b0;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
                sh_q  <= sh_q >> 1;
            end
        end
    end

endmodule

// File: rtl/usb_ls_nrzi_tx.sv
// Low-speed USB packet transmitter top. Sequences preamble J, NRZI bit
// stream, two-bit SE0, one-bit J and release; drives the pair and enable.
// Assumes clk runs at CLKS_PER_BIT times the bit rate and the byte source
// answers each fetch request in the following cycle.
module usb_ls_nrzi_tx
    import usb_ls_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int CNT_W        = 8,
    parameter int BYTE_W       = 8,
    parameter int STUFF_RUN    = 6,
    parameter int SE0_BITS     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    output logic              fetch_req_o,
    output logic [CNT_W-1:0]  fetch_idx_o,
    input  logic [BYTE_W-1:0] fetch_data_i,
    output logic              dp_o,
    output logic              dm_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int SW = $clog2(SE0_BITS + 1);
    localparam logic [SW-1:0] SE0_LAST = SW'(SE0_BITS - 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tx_state_e         state_q;
    logic [SW-1:0]     se0_q;
    logic              done_q;
    logic              accept;
    logic              run_w;
    logic              strobe_w;
    logic              take_w;
    logic              end_w;
    logic              line_k_w;
    logic              nxt_valid_w;
    logic [BYTE_W-1:0] nxt_byte_w;
    logic [1:0]        sym_w;

    assign accept = (state_q == ST_IDLE) && start_i && (byte_cnt_i != '0);
    assign run_w  = (state_q == ST_BITS) || (state_q == ST_EOP) || (state_q == ST_JEND);

    usb_tx_bit_timer #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_w),
        .strobe_o(strobe_w)
    );

    usb_tx_byte_feeder #(
        .CNT_W (CNT_W),
        .BYTE_W(BYTE_W)
    ) u_feeder (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .count_i     (byte_cnt_i - ONE),
        .active_i    ((state_q == ST_ARM) || (state_q == ST_BITS)),
        .take_i      (take_w),
        .fetch_req_o (fetch_req_o),
        .fetch_idx_o (fetch_idx_o),
        .fetch_data_i(fetch_data_i),
        .nxt_valid_o (nxt_valid_w),
        .nxt_byte_o  (nxt_byte_w)
    );

    usb_tx_nrzi_stuffer #(
        .BYTE_W   (BYTE_W),
        .STUFF_RUN(STUFF_RUN)
    ) u_stuffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (state_q == ST_ARM),
        .strobe_i   (strobe_w && (state_q == ST_BITS)),
        .nxt_valid_i(nxt_valid_w),
        .nxt_byte_i (nxt_byte_w),
        .take_o     (take_w),
        .end_o      (end_w),
        .line_k_o   (line_k_w)
    );

    // Packet sequencer: preamble, bits, SE0 bit slots, final J, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            se0_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) state_q <= ST_ARM;
                ST_ARM:  state_q <= ST_BITS;
                ST_BITS: begin
                    if (end_w) begin
                        state_q <= ST_EOP;
                        se0_q   <= '0;
                    end
                end
                ST_EOP: begin
                    if (strobe_w) begin
                        if (se0_q == SE0_LAST) state_q <= ST_JEND;
                        else                   se0_q   <= se0_q + 1'b1;
                    end
                end
                ST_JEND: begin
                    if (strobe_w) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Map sequencer state and line state to the pair symbol.
    always_comb begin
        unique case (state_q)
            ST_ARM, ST_JEND: sym_w = SYM_J;
            ST_BITS:         sym_w = line_k_w ? SYM_K : SYM_J;
            default:         sym_w = SYM_SE0;
        endcase
    end

    assign dp_o   = sym_w[1];
    assign dm_o   = sym_w[0];
    assign oe_o   = (state_q == ST_BITS) || (state_q == ST_EOP) || (state_q == ST_JEND);
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;

endmodule

// File: rtl/usb_ls_nrzi_tx_chk.sv
// Property checker for the transmitter, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module usb_ls_nrzi_tx_chk #(
    parameter int CLKS_PER_BIT = 8
) (
    input logic clk,
    input logic rst_n,
    input logic fetch_req_o,
    input logic dp_o,
    input logic dm_o,
    input logic oe_o,
    input logic busy_o,
    input logic done_o
);
    localparam int GW = $clog2(CLKS_PER_BIT + 1);
    localparam logic [GW-1:0] GFULL = GW'(CLKS_PER_BIT);

    logic [1:0]    sym_prev_q;
    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic          chg;

    assign chg = oe_o && ({dp_o, dm_o} != sym_prev_q);

    // Measure clocks between pair transitions while driving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_prev_q <= 2'b00;
            gap_q      <= '0;
            seen_q     <= 1'b0;
        end else begin
            sym_prev_q <= {dp_o, dm_o};
            if (!oe_o) begin
                gap_q  <= GW'(1);
                seen_q <= 1'b0;
            end else if (chg || gap_q == GFULL) begin
                gap_q  <= GW'(1);
                seen_q <= seen_q | chg;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!oe_o && !fetch_req_o));

    // R3
    enable_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> (!dp_o && dm_o));

    // R5
    no_se1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_o && dm_o));

    // R7
    bit_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && seen_q) |-> (gap_q == GFULL));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !oe_o) ##1 !done_o);

    // R10
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |=> !fetch_req_o);

endmodule

bind usb_ls_nrzi_tx usb_ls_nrzi_tx_chk #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_req_o(fetch_req_o),
    .dp_o       (dp_o),
    .dm_o       (dm_o),
    .oe_o       (oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/tb_usb_ls_nrzi_tx.sv
module tb_usb_ls_nrzi_tx;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 8;
    localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] byte_cnt_i = '0;
    logic       fetch_req_o;
    logic [7:0] fetch_idx_o;
    logic [7:0] fetch_data_i;
    logic       dp_o, dm_o, oe_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem [0:255];
    logic [1:0] exp_sym [0:4095];
    int         exp_len;
    int         fetch_cnt;
    int         fetch_bad;

    usb_ls_nrzi_tx dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
        .fetch_req_o(fetch_req_o), .fetch_idx_o(fetch_idx_o),
        .fetch_data_i(fetch_data_i), .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Byte source model: answers a request in the following cycle (R10).
    always @(posedge clk) begin
        if (fetch_req_o) begin
            fetch_data_i <= mem[fetch_idx_o];
            if (int'(fetch_idx_o) != fetch_cnt) fetch_bad <= fetch_bad + 1;
            fetch_cnt <= fetch_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected symbol stream from R4, R5, R6, R8.
    task automatic build_expect(input int n);
        logic [1:0] line = J;
        int ones = 0;
        exp_len = 0;
        for (int b = 0; b < n; b++) begin
            logic [7:0] by = (b == 0) ? 8'h80 : mem[b-1];
            for (int i = 0; i < 8; i++) begin
                if (!by[i]) begin
                    line = (line == J) ? K : J;
                    ones = 0;
                end else begin
                    ones++;
                end
                exp_sym[exp_len++] = line;
                if (ones == 6) begin
                    line = (line == J) ? K : J;
                    ones = 0;
                    exp_sym[exp_len++] = line;
                end
            end
        end
        exp_sym[exp_len++] = SE0;
        exp_sym[exp_len++] = SE0;
        exp_sym[exp_len++] = J;
    endtask

    // Send one packet and check every bit slot; inj >= 0 pulses a stray start.
    task automatic run_packet(input int n, input int inj, input string name);
        int bad = 0;
        int bad_k = -1;
        logic [1:0] bad_act = '0;
        int oe_bad = 0;
        build_expect(n);
        fetch_cnt = 0;
        fetch_bad = 0;
        @(negedge clk);
        start_i = 1'b1;
        byte_cnt_i = 8'(n);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !oe_o && {dp_o, dm_o} == J, "R3/R9", {name, " preamble J, oe low, busy"},
            {busy_o, oe_o, dp_o, dm_o}, {1'b1, 1'b0, J});
        @(posedge clk);
        @(negedge clk);
        chk(oe_o && {dp_o, dm_o} == J, "R3", {name, " J with oe high"},
            {oe_o, dp_o, dm_o}, {1'b1, J});
        for (int k = 0; k < exp_len; k++) begin
            int waits = BIT_CLKS - 1;
            @(posedge clk);
            @(negedge clk);
            if ({dp_o, dm_o} != exp_sym[k] && bad == 0) begin
                bad_k = k;
                bad_act = {dp_o, dm_o};
            end
            if ({dp_o, dm_o} != exp_sym[k]) bad++;
            if (!oe_o || !busy_o) oe_bad++;
            if (k == inj) begin
                start_i = 1'b1;
                byte_cnt_i = 8'd5;
                @(negedge clk);
                start_i = 1'b0;
                waits = BIT_CLKS - 2;
            end
            repeat (waits) @(posedge clk);
        end
        chk(bad == 0, "R4/R5/R6/R7/R8", {name, " symbol stream (first bad slot value)"},
            int'(bad_act), (bad_k >= 0) ? int'(exp_sym[bad_k]) : 0);
        chk(oe_bad == 0, "R9", {name, " oe and busy held through packet"}, oe_bad, 0);
        @(posedge clk);
        @(negedge clk);
        chk(!oe_o && !busy_o && done_o, "R8/R9", {name, " release with done"},
            {oe_o, busy_o, done_o}, 3'b001);
        @(posedge clk);
        @(negedge clk);
        chk(!done_o, "R9", {name, " done is one cycle"}, done_o, 0);
        chk(fetch_cnt == n - 1 && fetch_bad == 0, "R10", {name, " fetch count and order"},
            fetch_cnt, n - 1);
    endtask

    task automatic test_reset();
        chk(!oe_o, "R1", "reset oe", oe_o, 0);
        chk(!busy_o, "R1", "reset busy", busy_o, 0);
        chk(!done_o, "R1", "reset done", done_o, 0);
        chk(!fetch_req_o, "R1", "reset fetch_req", fetch_req_o, 0);
    endtask

    task automatic test_zero_count();
        int seen = 0;
        @(negedge clk);
        start_i = 1'b1;
        byte_cnt_i = 8'd0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (busy_o || oe_o || fetch_req_o) seen++;
        end
        chk(seen == 0, "R2", "count 0 start ignored", seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_zero_count();
        run_packet(1, -1, "R4 sync only");
        mem[0] = 8'hA5; mem[1] = 8'h3C;
        run_packet(3, -1, "R5 mixed");
        mem[0] = 8'hFF; mem[1] = 8'hFF; mem[2] = 8'hFF;
        run_packet(4, -1, "R6 all ones");
        mem[0] = 8'hFC;
        run_packet(2, -1, "R6 stuff before eop");
        mem[0] = 8'h00; mem[1] = 8'h00;
        run_packet(3, -1, "R5 zeros");
        mem[0] = 8'h5A; mem[1] = 8'hC3; mem[2] = 8'h7E; mem[3] = 8'h81;
        run_packet(5, 12, "R2 start while busy");
        for (int i = 0; i < 254; i++) mem[i] = 8'(i * 37 + 11);
        run_packet(255, -1, "R10 max length");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule